// File: doc/BRIEF.md
# Multicycle CPU Exception Detector

This block sits beside the sequencer of a five-step, 32-bit multicycle processor. It watches three things: the step number the sequencer is in, the primary opcode field of the instruction register, and the program counter. From these it finds two kinds of fault. The first is an instruction whose primary opcode is not one the core implements. The second is a fetch from a PC that lies outside the code half of the core's shared 32-word memory.

When it finds a fault, the detector raises a one-cycle strobe. The sequencer uses that strobe to drop the current instruction, suppressing the fetch for a PC fault, and to restart at step 1 from a fixed handler address. That address is always present on the redirect output. In the same cycle the detector latches a cause code and the address of the offending instruction. After the strobe it waits for an acknowledge from the sequencer before it will report another fault.

Steps are numbered as follows: 1 fetch, 2 decode and register read, 3 execute, 4 memory access or register write-back, 5 load write-back. Opcode legality is judged only in step 3. PC range is judged only in step 1.

The internal monitor has two states and three transitions:
- WATCH: faults are reported here. A detected fault moves it to HOLD.
- HOLD: faults are not reported. An acknowledge moves it back to WATCH. With no acknowledge it stays in HOLD.
- Reset: puts it in WATCH from any state.

Top module: `exc_detector`

## Requirements
- R1: While reset is high and after it is released, before any fault, the strobe is 0, the cause is 2'b00 and the EPC is 0.
- R2: In WATCH, if the step input is 1 and the PC's word index (PC bits 6:2) is 16 or more, the strobe is 1 in that same cycle. From the next cycle the cause is 2'b10 and the EPC equals that PC.
- R3: In WATCH, if the step input is 1 and any PC bit above bit 6 is set, this is a PC fault with cause 2'b10, whatever the word index is.
- R4: A step-1 PC from 0x00 to 0x3C gives no strobe. A PC that is out of range gives no strobe in any step other than 1.
- R5: In WATCH, if the step input is 3 and the opcode is outside the legal set, the strobe is 1 in that cycle. From the next cycle the cause is 2'b01 and the EPC equals PC minus 4.
- R6: The legal opcodes are 000000, 100011, 101011, 000100 and 000010. They never give a strobe. An illegal opcode gives no strobe in any step other than 3.
- R7: The strobe lasts one cycle. After it, no fault gives a strobe or changes the cause or EPC until the acknowledge input has been sampled high.
- R8: The cause and EPC keep their values until the next reported fault or reset. An acknowledge while in WATCH changes nothing.
- R9: The redirect output always equals the handler address 0x3C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| ctl_step | input | 3 | Sequencer step number (1 to 5) |
| opcode | input | 6 | Primary opcode field, instruction bits 31:26 |
| pc | input | 32 | Program counter, byte address |
| ack | input | 1 | Sequencer has taken the redirect |
| exc_strobe | output | 1 | One-cycle fault pulse; suppresses fetch and forces redirect |
| exc_cause | output | 2 | Latched cause: 01 undefined opcode, 10 PC out of code space |
| exc_epc | output | 32 | Latched address of the offending instruction |
| redirect_pc | output | 32 | Handler address for the sequencer to load |

## Verification
The properties assume that the sequencer holds step, opcode and PC stable across each clock edge, and that it only presents step values from 1 to 5. They also assume that at most one fault is possible per cycle, because the two kinds of fault belong to different steps. The stimulus follows these assumptions. It drives all inputs at the falling edge. It pairs each fault with a step-1 cycle that carries the acknowledge, and it inserts faults during HOLD on purpose to exercise the suppression window.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int STEP_W = 3;
    localparam int OP_W   = 6;

    localparam logic [STEP_W-1:0] STEP_FETCH = 3'd1;
    localparam logic [STEP_W-1:0] STEP_EXEC  = 3'd3;

    localparam logic [OP_W-1:0] OPC_REG    = 6'b000000;
    localparam logic [OP_W-1:0] OPC_LOAD   = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE  = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BRANCH = 6'b000100;
    localparam logic [OP_W-1:0] OPC_JUMP   = 6'b000010;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_OPCODE  = 2'b01,
        CAUSE_PCRANGE = 2'b10
    } cause_e;

    typedef enum logic {
        MON_WATCH = 1'b0,
        MON_HOLD  = 1'b1
    } mon_e;

endpackage

// File: rtl/exc_opcode_chk.sv
module exc_opcode_chk
    import exc_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output logic            legal
);

    always_comb begin
        unique case (opcode)
            OPC_REG, OPC_LOAD, OPC_STORE, OPC_BRANCH, OPC_JUMP: legal = 1'b1;
            default:                                            legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/exc_pc_chk.sv
module exc_pc_chk #(
    parameter int PC_W       = 32,
    parameter int MEM_WORDS  = 32,
    parameter int CODE_WORDS = 16
) (
    input  logic [PC_W-1:0] pc,
    output logic            outside_code
);

    localparam int             IDX_W    = $clog2(MEM_WORDS);
    localparam int             TOP_LSB  = IDX_W + 2;
    localparam logic [IDX_W:0] CODE_LIM = CODE_WORDS[IDX_W:0];

    logic [IDX_W-1:0] word_idx;
    logic             idx_high;
    logic             upper_set;

    assign word_idx = pc[TOP_LSB-1:2];
    assign idx_high = ({1'b0, word_idx} >= CODE_LIM);

    generate
        if (PC_W > TOP_LSB) begin : g_upper
            assign upper_set = |pc[PC_W-1:TOP_LSB];
        end else begin : g_no_upper
            assign upper_set = 1'b0;
        end
    endgenerate

    assign outside_code = idx_high | upper_set;

endmodule

// File: rtl/exc_capture.sv
module exc_capture #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [1:0]      cause_in,
    input  logic [PC_W-1:0] epc_in,
    output logic [1:0]      cause_q,
    output logic [PC_W-1:0] epc_q
);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cause_q <= 2'b00;
            epc_q   <= '0;
        end else if (load) begin
            cause_q <= cause_in;
            epc_q   <= epc_in;
        end
    end

endmodule

// File: rtl/exc_detector.sv
module exc_detector
    import exc_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter int              MEM_WORDS  = 32,
    parameter int              CODE_WORDS = 16,
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_003C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STEP_W-1:0] ctl_step,
    input  logic [OP_W-1:0]   opcode,
    input  logic [PC_W-1:0]   pc,
    input  logic              ack,
    output logic              exc_strobe,
    output logic [1:0]        exc_cause,
    output logic [PC_W-1:0]   exc_epc,
    output logic [PC_W-1:0]   redirect_pc
);

    localparam logic [PC_W-1:0] INSTR_BYTES = PC_W'(4);

    mon_e            mon_q, mon_d;
    logic            op_legal;
    logic            pc_outside;
    logic            pc_fault;
    logic            op_fault;
    cause_e          cause_sel;
    logic [PC_W-1:0] epc_sel;

    exc_opcode_chk u_op (
        .opcode (opcode),
        .legal  (op_legal)
    );

    exc_pc_chk #(
        .PC_W       (PC_W),
        .MEM_WORDS  (MEM_WORDS),
        .CODE_WORDS (CODE_WORDS)
    ) u_pc (
        .pc           (pc),
        .outside_code (pc_outside)
    );

    assign pc_fault = (ctl_step == STEP_FETCH) && pc_outside;
    assign op_fault = (ctl_step == STEP_EXEC) && !op_legal;

    // PC fault wins over opcode fault
    always_comb begin
        if (pc_fault) begin
            cause_sel = CAUSE_PCRANGE;
            epc_sel   = pc;
        end else begin
            cause_sel = CAUSE_OPCODE;
            epc_sel   = pc - INSTR_BYTES;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) mon_q <= MON_WATCH;
        else     mon_q <= mon_d;
    end

    always_comb begin
        mon_d      = mon_q;
        exc_strobe = 1'b0;
        unique case (mon_q)
            MON_WATCH: begin
                if (pc_fault || op_fault) begin
                    exc_strobe = 1'b1;
                    mon_d      = MON_HOLD;
                end
            end
            MON_HOLD: begin
                if (ack) mon_d = MON_WATCH;
            end
            default: mon_d = MON_WATCH;
        endcase
    end

    exc_capture #(.PC_W(PC_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .load     (exc_strobe),
        .cause_in (cause_sel),
        .epc_in   (epc_sel),
        .cause_q  (exc_cause),
        .epc_q    (exc_epc)
    );

    assign redirect_pc = HANDLER_PC;

endmodule

// File: rtl/exc_detector_sva.sv
module exc_detector_sva #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [2:0]      ctl_step,
    input logic [PC_W-1:0] pc,
    input logic            exc_strobe,
    input logic [1:0]      exc_cause,
    input logic [PC_W-1:0] exc_epc
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (exc_cause == 2'b00 && exc_epc == '0));

    a_r2_pc_capture: assert property (@(posedge clk) disable iff (rst)
        (exc_strobe && ctl_step == 3'd1) |=>
            (exc_cause == 2'b10 && exc_epc == $past(pc)));

    a_r5_op_capture: assert property (@(posedge clk) disable iff (rst)
        (exc_strobe && ctl_step == 3'd3) |=>
            (exc_cause == 2'b01 && exc_epc == $past(pc) - PC_W'(4)));

    a_r4_step_window: assert property (@(posedge clk) disable iff (rst)
        exc_strobe |-> (ctl_step == 3'd1 || ctl_step == 3'd3));

    a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
        exc_strobe |=> !exc_strobe);

    a_r8_hold_values: assert property (@(posedge clk) disable iff (rst)
        !exc_strobe |=> ($stable(exc_cause) && $stable(exc_epc)));

endmodule

bind exc_detector exc_detector_sva #(.PC_W(PC_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .ctl_step   (ctl_step),
    .pc         (pc),
    .exc_strobe (exc_strobe),
    .exc_cause  (exc_cause),
    .exc_epc    (exc_epc)
);

// File: tb/sim_exc_detector.sv
`timescale 1ns/1ps
module sim_exc_detector;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  ctl_step;
    logic [5:0]  opcode;
    logic [31:0] pc;
    logic        ack;
    logic        exc_strobe;
    logic [1:0]  exc_cause;
    logic [31:0] exc_epc;
    logic [31:0] redirect_pc;

    always #2.5 clk = ~clk;

    exc_detector u0 (
        .clk         (clk),
        .rst         (rst),
        .ctl_step    (ctl_step),
        .opcode      (opcode),
        .pc          (pc),
        .ack         (ack),
        .exc_strobe  (exc_strobe),
        .exc_cause   (exc_cause),
        .exc_epc     (exc_epc),
        .redirect_pc (redirect_pc)
    );

    typedef struct {
        logic [1:0]  cause;
        logic [31:0] epc;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;
    bit          m_hold = 1'b0;
    logic [1:0]  m_cause = 2'b00;
    logic [31:0] m_epc = 32'h0;

    function automatic bit op_ok(input logic [5:0] o);
        return (o == 6'b000000) || (o == 6'b100011) || (o == 6'b101011) ||
               (o == 6'b000100) || (o == 6'b000010);
    endfunction

    function automatic bit pc_bad(input logic [31:0] p);
        return p >= 32'h40;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // driver: applies one cycle, checks the combinational strobe, queues the latched result
    task automatic step(input logic [2:0] st, input logic [5:0] op,
                        input logic [31:0] p, input logic a, input string tag);
        bit   fire;
        exp_t e;
        @(negedge clk);
        ctl_step = st;
        opcode   = op;
        pc       = p;
        ack      = a;
        #1;
        fire = !m_hold && ((st == 3'd1 && pc_bad(p)) || (st == 3'd3 && !op_ok(op)));
        chk({tag, " strobe"}, 64'(exc_strobe), 64'(fire));
        if (fire) begin
            m_hold = 1'b1;
            if (st == 3'd1) begin
                m_cause = 2'b10;
                m_epc   = p;
            end else begin
                m_cause = 2'b01;
                m_epc   = p - 32'd4;
            end
        end else if (m_hold && a) begin
            m_hold = 1'b0;
        end
        e.cause = m_cause;
        e.epc   = m_epc;
        e.tag   = tag;
        sb.push_back(e);
    endtask

    // monitor: compares latched outputs after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " cause"}, 64'(exc_cause), 64'(e.cause));
                chk({e.tag, " epc"},   64'(exc_epc),   64'(e.epc));
            end
        end
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        rst = 1'b1; ctl_step = 3'd1; opcode = 6'd0; pc = 32'h0; ack = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset strobe", 64'(exc_strobe), 64'd0);
        chk("R1 reset cause",  64'(exc_cause),  64'd0);
        chk("R1 reset epc",    64'(exc_epc),    64'd0);
        chk("R9 redirect",     64'(redirect_pc), 64'h3C);
        @(negedge clk);
        rst = 1'b0;

        // R4 R6: clean program flow through all code words
        for (int i = 0; i < 16; i++) begin
            step(3'd1, 6'b000000, 32'(i * 4), 1'b0, "R4 fetch in range");
            step(3'd2, 6'b100011, 32'(i * 4 + 4), 1'b0, "R6 decode");
            step(3'd3, 6'b100011, 32'(i * 4 + 4), 1'b0, "R6 legal exec");
        end

        // R5: undefined opcode
        step(3'd3, 6'b111111, 32'h14, 1'b0, "R5 bad opcode");
        // R7: faults while holding are ignored
        step(3'd1, 6'b000000, 32'h40, 1'b0, "R7 pc fault in hold");
        step(3'd3, 6'b010101, 32'h20, 1'b0, "R7 op fault in hold");
        step(3'd1, 6'b000000, 32'h3C, 1'b1, "R7 ack");

        // R2: word index 16
        step(3'd1, 6'b000000, 32'h40, 1'b0, "R2 pc word 16");
        step(3'd1, 6'b000000, 32'h3C, 1'b1, "R2 ack");
        step(3'd1, 6'b000000, 32'h7C, 1'b0, "R2 pc word 31");
        step(3'd1, 6'b000000, 32'h3C, 1'b1, "R2 ack");

        // R3: upper PC bits
        step(3'd1, 6'b000000, 32'h80, 1'b0, "R3 pc bit7");
        step(3'd1, 6'b000000, 32'h3C, 1'b1, "R3 ack");
        step(3'd1, 6'b000000, 32'h8000_0004, 1'b0, "R3 pc bit31");
        step(3'd1, 6'b000000, 32'h3C, 1'b1, "R3 ack");

        // R4 R6: faults outside their step
        step(3'd2, 6'b111111, 32'h44, 1'b0, "R6 bad op in step2");
        step(3'd4, 6'b110000, 32'h88, 1'b0, "R6 bad op in step4");
        step(3'd5, 6'b000001, 32'h100, 1'b0, "R4 bad pc in step5");
        step(3'd3, 6'b000100, 32'h200, 1'b0, "R4 bad pc in step3");

        // R8: ack while watching has no effect
        step(3'd1, 6'b000000, 32'h08, 1'b1, "R8 idle ack");
        step(3'd1, 6'b000000, 32'h0C, 1'b1, "R8 idle ack");

        // R5 R6: sweep of every opcode
        for (int o = 0; o < 64; o++) begin
            step(3'd3, 6'(o), 32'(8 + (o % 14) * 4), 1'b0, "R5 sweep");
            step(3'd1, 6'b000000, 32'h3C, 1'b1, "R6 sweep ack");
        end

        // R8: new fault replaces the latched values
        step(3'd3, 6'b001000, 32'h30, 1'b0, "R8 update op");
        step(3'd1, 6'b000000, 32'h3C, 1'b1, "R8 ack");
        step(3'd1, 6'b000000, 32'h50, 1'b0, "R8 update pc");
        step(3'd2, 6'b000000, 32'h3C, 1'b0, "R8 hold");

        @(negedge clk);
        @(negedge clk);
        finish_up();
    end

endmodule